// File: doc/BRIEF.md
# DMA Controller Configuration Register Block

This block is the software-visible register front end of a 14-channel DMA controller. It holds the global enable bit and the primary control-structure base pointer. It derives the alternate control-structure base pointer in hardware, so software never has to compute it. It also keeps one pending software request bit per channel. The channel engine sees the enable, both base pointers and the gated request lines. It reports completion back through one done pulse per channel.

Access is through a simple single-cycle register port with a byte address, a write strobe and write data. Read data is returned combinationally for the address currently presented. The port has no valid/ready pair and never applies back-pressure: every write is taken on the clock edge on which `reg_wr` is high. Software request bits are write-one-to-set. Each bit clears itself when the engine pulses that channel's done line. A new set in the same cycle as a done pulse keeps the bit set.

The base pointer must be aligned to 5 + log2(M) bits, where M is the channel count rounded up to a power of two (16 here). The low 9 bits of the primary pointer are therefore forced to zero. Each channel structure takes 16 bytes, so the alternate base is the primary base plus 0x100.

Top module: `dma_cfg_regs`

## Requirements
- R1: After reset, `ctl_enable` is 0, `ctl_pri_base` is 0, `sw_req` is 0, and a read of offset 0x0C returns 0x00000100.
- R2: A write to offset 0x04 loads bit 0 of the write data into the enable, which is output on `ctl_enable` from the next cycle. A read of 0x04 returns the enable in bit 0 and zero in bits 31:1.
- R3: A write to offset 0x08 stores the write data with bits 8:0 forced to zero. The stored value appears on `ctl_pri_base` and on reads of 0x08, and it is unchanged by writes to any other address.
- R4: `ctl_alt_base` and reads of offset 0x0C equal the primary base plus 0x100 (modulo 2^32). Writes to 0x0C have no effect.
- R5: Writing offset 0x14 with bit C = 1 (C in 0..13) sets pending request C. Bits written 0 and write bits 31:14 leave all pending bits unchanged. A read of 0x14 returns the pending bits in 13:0 and zero in 31:14.
- R6: A pulse on `ch_done[C]` clears pending request C on that clock edge.
- R7: If `ch_done[C]` and a write of 1 to request bit C occur on the same edge, request C stays set.
- R8: `sw_req` equals the pending bits while the enable is 1 and is all zero while it is 0. Pending bits are kept while the enable is 0.
- R9: Only the exact byte offsets 0x04, 0x08, 0x0C and 0x14 are registers. Reads of every other offset return zero, and writes to them change no state.
- R10: While `rst_n` is low, reads of offsets 0x08 and 0x0C return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ctl_enable | output | 1 | Global controller enable |
| ctl_pri_base | output | 32 | Primary control-structure base |
| ctl_alt_base | output | 32 | Alternate control-structure base |
| sw_req | output | 14 | Software request per channel, gated by the enable |
| ch_done | input | 14 | Per-channel completion pulse from the engine |

## Verification
The primary pointer is exercised with a walking one across all 32 bits, plus an all-ones value and a set of multiplicative-hash patterns. This separates wrong masking of the alignment bits from a wrong alternate offset or a carry error near the top of the range. The request bits are driven in three ways: one channel at a time with a single done pulse, with all 32 write bits set at once, and with a set and a done on the same edge. These patterns tell apart a wrong bit position, a leak from the reserved write bits and the wrong priority between set and clear. A sweep over all 256 byte offsets, with ones written to every non-register offset, shows that decoding is exact. Enable toggling and a reset asserted mid-run expose gating and read-in-reset faults.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;

  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_CFG = 8'h04;
  localparam logic [REG_AW-1:0] OFS_PRI = 8'h08;
  localparam logic [REG_AW-1:0] OFS_ALT = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_SWR = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CFG  = 3'd1,
    SEL_PRI  = 3'd2,
    SEL_ALT  = 3'd3,
    SEL_SWR  = 3'd4
  } reg_sel_e;

  // number of low pointer bits that must stay zero
  function automatic int unsigned align_bits(input int unsigned n_ch);
    return 5 + $clog2(n_ch);
  endfunction

  // byte distance from the primary structure to the alternate one
  function automatic int unsigned alt_offset(input int unsigned n_ch,
                                             input int unsigned slot_bytes);
    return (1 << $clog2(n_ch)) * slot_bytes;
  endfunction

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
  import dma_cfg_pkg::*;
(
  input  logic [REG_AW-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    unique case (addr)
      OFS_CFG: sel = SEL_CFG;
      OFS_PRI: sel = SEL_PRI;
      OFS_ALT: sel = SEL_ALT;
      OFS_SWR: sel = SEL_SWR;
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dma_cfg_baseptr.sv
module dma_cfg_baseptr
  import dma_cfg_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned NUM_CH     = 14,
  parameter int unsigned SLOT_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_pri,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pri_base,
  output logic [DW-1:0] alt_base
);
  localparam int unsigned ALIGN   = align_bits(NUM_CH);
  localparam int unsigned ALT_OFS = alt_offset(NUM_CH, SLOT_BYTES);
  localparam logic [DW-1:0] KEEP  = ~((DW'(1) << ALIGN) - DW'(1));

  logic [DW-1:0] pri_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pri_q <= '0;
    else if (wr_pri) pri_q <= wdata & KEEP;
  end

  assign pri_base = pri_q;
  assign alt_base = pri_q + DW'(ALT_OFS);
endmodule

// File: rtl/dma_cfg_swreq.sv
module dma_cfg_swreq #(
  parameter int unsigned NUM_CH = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_swr,
  input  logic [NUM_CH-1:0] set_bits,
  input  logic [NUM_CH-1:0] done,
  input  logic              enable,
  output logic [NUM_CH-1:0] pending,
  output logic [NUM_CH-1:0] req
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic pend_q;
    logic set_c;
    assign set_c = wr_swr & set_bits[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (set_c)   pend_q <= 1'b1;   // a new request beats completion
      else if (done[c]) pend_q <= 1'b0;
    end

    assign pending[c] = pend_q;
    assign req[c]     = pend_q & enable;
  end
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_cfg_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned NUM_CH     = 14,
  parameter int unsigned SLOT_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              ctl_enable,
  output logic [DW-1:0]     ctl_pri_base,
  output logic [DW-1:0]     ctl_alt_base,
  output logic [NUM_CH-1:0] sw_req,
  input  logic [NUM_CH-1:0] ch_done
);
  reg_sel_e          sel;
  logic              en_q;
  logic [NUM_CH-1:0] pending;

  dma_cfg_decode u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       en_q <= 1'b0;
    else if (reg_wr && sel == SEL_CFG) en_q <= reg_wdata[0];
  end

  dma_cfg_baseptr #(
    .DW(DW), .NUM_CH(NUM_CH), .SLOT_BYTES(SLOT_BYTES)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_pri   (reg_wr && sel == SEL_PRI),
    .wdata    (reg_wdata),
    .pri_base (ctl_pri_base),
    .alt_base (ctl_alt_base)
  );

  dma_cfg_swreq #(.NUM_CH(NUM_CH)) u_swr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_swr   (reg_wr && sel == SEL_SWR),
    .set_bits (reg_wdata[NUM_CH-1:0]),
    .done     (ch_done),
    .enable   (en_q),
    .pending  (pending),
    .req      (sw_req)
  );

  assign ctl_enable = en_q;

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_CFG: reg_rdata[0] = en_q;
      SEL_PRI: reg_rdata = rst_n ? ctl_pri_base : '0;
      SEL_ALT: reg_rdata = rst_n ? ctl_alt_base : '0;
      SEL_SWR: reg_rdata[NUM_CH-1:0] = pending;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_cfg_regs_chk.sv
module dma_cfg_regs_chk
  import dma_cfg_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned NUM_CH     = 14,
  parameter int unsigned SLOT_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic              ctl_enable,
  input logic [DW-1:0]     ctl_pri_base,
  input logic [DW-1:0]     ctl_alt_base,
  input logic [NUM_CH-1:0] sw_req,
  input logic [NUM_CH-1:0] ch_done
);
  localparam int unsigned ALIGN   = align_bits(NUM_CH);
  localparam int unsigned ALT_OFS = alt_offset(NUM_CH, SLOT_BYTES);
  localparam logic [DW-1:0] KEEP  = ~((DW'(1) << ALIGN) - DW'(1));

  logic wr_cfg, wr_pri, wr_swr, known;
  logic [NUM_CH-1:0] setm;
  assign wr_cfg = reg_wr && reg_addr == OFS_CFG;
  assign wr_pri = reg_wr && reg_addr == OFS_PRI;
  assign wr_swr = reg_wr && reg_addr == OFS_SWR;
  assign known  = reg_addr == OFS_CFG || reg_addr == OFS_PRI ||
                  reg_addr == OFS_ALT || reg_addr == OFS_SWR;
  assign setm   = wr_swr ? reg_wdata[NUM_CH-1:0] : '0;

  p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> ctl_enable == $past(reg_wdata[0]));

  p_pri_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pri |=> ctl_pri_base == ($past(reg_wdata) & KEEP));

  p_pri_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pri |=> $stable(ctl_pri_base));

  p_alt_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_alt_base - ctl_pri_base == DW'(ALT_OFS));

  p_set_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_swr && ctl_enable && !wr_cfg) |=>
      (sw_req & $past(setm)) == $past(setm));

  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_done & ~setm)) |=> (sw_req & $past(ch_done & ~setm)) == '0);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |-> sw_req == '0);

  p_rsv_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> reg_rdata == '0);
endmodule

bind dma_cfg_regs dma_cfg_regs_chk #(
  .DW(DW), .NUM_CH(NUM_CH), .SLOT_BYTES(SLOT_BYTES)
) u_chk (.*);

// File: tb/sim_dma_cfg_regs.sv
`timescale 1ns/1ps
module sim_dma_cfg_regs;
  localparam int NCH = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ctl_enable;
  logic [31:0] ctl_pri_base, ctl_alt_base;
  logic [NCH-1:0] sw_req;
  logic [NCH-1:0] ch_done = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_cfg_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_enable(ctl_enable),
    .ctl_pri_base(ctl_pri_base), .ctl_alt_base(ctl_alt_base),
    .sw_req(sw_req), .ch_done(ch_done)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_done(input logic [NCH-1:0] m);
    @(negedge clk);
    ch_done = m;
    @(negedge clk);
    ch_done = '0;
  endtask

  function automatic logic [31:0] mask_ptr(input logic [31:0] d);
    return d & 32'hFFFF_FE00;
  endfunction

  initial begin
    logic [31:0] r;
    logic [31:0] pri_exp;
    logic [NCH-1:0] pend_exp;

    // R10 / R1: reads while held in reset, then reset values
    repeat (2) @(negedge clk);
    rd(8'h08, r); check("R10 pri in reset", r, 32'h0);
    rd(8'h0C, r); check("R10 alt in reset", r, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 enable", {31'b0, ctl_enable}, 32'h0);
    check("R1 pri", ctl_pri_base, 32'h0);
    check("R1 sw_req", {18'b0, sw_req}, 32'h0);
    rd(8'h0C, r); check("R1 alt read", r, 32'h100);

    // R2 enable
    wr(8'h04, 32'h1);
    check("R2 enable set", {31'b0, ctl_enable}, 32'h1);
    rd(8'h04, r); check("R2 cfg read", r, 32'h1);
    wr(8'h04, 32'hFFFF_FFFE);
    check("R2 enable clear by bit0", {31'b0, ctl_enable}, 32'h0);
    rd(8'h04, r); check("R2 cfg read 0", r, 32'h0);

    // R3 / R4 pointer sweep: walking one, all-ones, hashes
    for (int i = 0; i < 48; i++) begin
      logic [31:0] d;
      if (i < 32) d = 32'h1 << i;
      else if (i == 32) d = 32'hFFFF_FFFF;
      else d = (i * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
      wr(8'h08, d);
      pri_exp = mask_ptr(d);
      check("R3 pri out", ctl_pri_base, pri_exp);
      rd(8'h08, r); check("R3 pri read", r, pri_exp);
      check("R4 alt out", ctl_alt_base, pri_exp + 32'h100);
      rd(8'h0C, r); check("R4 alt read", r, pri_exp + 32'h100);
    end
    wr(8'h08, 32'h1234_56FF);
    pri_exp = 32'h1234_5600;
    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h0C, r); check("R4 alt write ignored", r, pri_exp + 32'h100);
    check("R3 pri after alt write", ctl_pri_base, pri_exp);

    // R5 / R6 per channel, enable on
    wr(8'h04, 32'h1);
    for (int c = 0; c < NCH; c++) begin
      wr(8'h14, 32'h1 << c);
      check("R5 set one", {18'b0, sw_req}, 32'h1 << c);
      wr(8'h14, 32'h0);
      check("R5 zero write no effect", {18'b0, sw_req}, 32'h1 << c);
      pulse_done(NCH'(1) << c);
      check("R6 done clears", {18'b0, sw_req}, 32'h0);
    end
    wr(8'h14, 32'hFFFF_C000);
    rd(8'h14, r); check("R5 reserved bits ignored", r, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, r); check("R5 all set read", r, 32'h0000_3FFF);
    pulse_done(14'h0155);
    pend_exp = 14'h3FFF & ~14'h0155;
    check("R6 partial clear", {18'b0, sw_req}, {18'b0, pend_exp});

    // R7 set and done on the same edge
    @(negedge clk);
    reg_addr = 8'h14; reg_wdata = 32'h0000_0001; reg_wr = 1'b1;
    ch_done = 14'h0003;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; ch_done = '0;
    pend_exp = (pend_exp & ~14'h0003) | 14'h0001;
    check("R7 set wins over done", {18'b0, sw_req}, {18'b0, pend_exp});

    // R8 gating and retention
    wr(8'h04, 32'h0);
    check("R8 gated off", {18'b0, sw_req}, 32'h0);
    rd(8'h14, r); check("R8 kept while disabled", r, {18'b0, pend_exp});
    wr(8'h04, 32'h1);
    check("R8 re-enabled", {18'b0, sw_req}, {18'b0, pend_exp});

    // R9 address sweep: hit every non-register offset with ones
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h04 && a != 8'h08 && a != 8'h0C && a != 8'h14)
        wr(a[7:0], 32'hFFFF_FFFF);
    end
    @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      logic [31:0] e;
      case (a)
        8'h04:   e = 32'h1;
        8'h08:   e = pri_exp;
        8'h0C:   e = pri_exp + 32'h100;
        8'h14:   e = {18'b0, pend_exp};
        default: e = 32'h0;
      endcase
      rd(a[7:0], r); check("R9 address sweep", r, e);
    end

    // R10 reset asserted mid-run
    @(negedge clk); rst_n = 1'b0;
    rd(8'h08, r); check("R10 pri read in reset", r, 32'h0);
    rd(8'h0C, r); check("R10 alt read in reset", r, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(8'h0C, r); check("R1 alt after reset", r, 32'h100);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule